// File: doc/BRIEF.md
# Multi-Task Page Mapping Unit

This unit translates addresses for a processor. It holds a page map for each task on chip. Virtual address bits 26:18 pick one of 512 pages of 256 kB each, inside a 128 MB window. The map entry for that page supplies the physical bits 27:18. All other address bits pass through unchanged. Accesses flagged as I/O are never translated.

Software reaches the maps and the control registers through a small I/O register window. It uses two keys. The access key chooses which task's map the bus reaches. The operate key chooses which task translates while the processor runs in user mode. Each unit has a 3-bit unit identifier register. Several units can share one register window and are told apart by key matching. A kernel-entry pulse puts the unit in supervisor mode, where task 0 translates. Supervisor mode ends only when a countdown fuse, written by software, runs out.

The countdown is a three-state machine. SUPER means supervisor mode with no countdown running. ARMED means supervisor mode with the fuse counting down. USER means supervisor mode has been left.
- SUPER goes to ARMED on a fuse write (transition LOAD).
- ARMED stays in ARMED on a new fuse write (RELOAD).
- ARMED goes to USER when the count passes 0 to -1 (EXPIRE).
- Any state goes to SUPER on kernel entry (TRAP). TRAP has priority over every other transition.

Top module: `pmu_top`

## Requirements
- R1: After reset:
  - translation is disabled, so `pa` equals `va`;
  - the supervisor bit reads 1;
  - the access key, operate key and enable register read 0;
  - the fuse reads 0xFFFF (idle).
- R2: While translation is on for this unit and `va_io` is low, `pa[27:18]` is bits 9:0 of the active task's entry at index `va[26:18]`. All other bits of `pa` equal those of `va`.
- R3: While `va_io` is high, or while the enable bit (offset 0x418, bit 0) is clear, `pa` equals `va`.
- R4: Map entries sit at byte offset 2*index, from 0x000 to 0x3FE.
  - The bus may read or write an entry only when all of these hold: access key bits 7:5 equal the unit identifier, the supervisor bit is 1, and access key bits 4:0 name an existing task (below 4 by default).
  - Access key bits 4:0 select the task.
  - A refused read returns 0. A refused write leaves the entry unchanged.
- R5: A map entry keeps the physical page in bits 9:0 and write protection in bit 15. Bits 14:10 read as 0.
- R6: The active task depends on the supervisor bit.
  - When the supervisor bit is 1, task 0 is active.
  - When it is 0, operate key (offset 0x416) bits 4:0 name the task, provided bits 7:5 equal the unit identifier.
  - Otherwise this unit does not translate.
- R7: After a fuse write of N (offset 0x412), the fuse reads N, then N-1, and so on, one step per clock. The supervisor bit clears on the (N+1)-th rising edge after the write edge, when the count reaches -1. The fuse then reads 0xFFFF.
- R8: The supervisor bit (offset 0x410, bit 0) is read-only. Bus writes to it have no effect.
- R9: A kernel-entry pulse sets the supervisor bit and cancels the countdown, so the fuse reads 0xFFFF. It wins over an expiry or a fuse write in the same cycle.
- R10: A valid, translated write to a page whose entry has bit 15 set raises `wp_fault` for exactly the next cycle. The address is still translated.
- R11: The unit identifier register sits at offset 0x400 + 2*UNIT_ID and keeps 3 bits. The other seven identifier slots from 0x400 to 0x40E read 0.
- R12: A fuse write during a running countdown restarts it from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_enter | input | 1 | Pulse on interrupt or exception entry |
| io_sel | input | 1 | Register window access strobe |
| io_we | input | 1 | Write when high, read when low |
| io_addr | input | 12 | Byte offset into the register window; bit 0 must be 0 |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational |
| va_valid | input | 1 | Translation request valid |
| va_write | input | 1 | Request is a write |
| va_io | input | 1 | Request is an I/O access, never translated |
| va | input | 64 | Virtual address |
| pa | output | 64 | Physical address, combinational |
| wp_fault | output | 1 | One-cycle write-protect fault flag |

## Verification
A kernel-entry pulse can land in the same cycle as the countdown's expiry. It can also land in the same cycle as a fresh fuse write.

The bench forces the first case by loading the fuse with 1 and raising `kernel_enter` on the second edge after the load, which is the expiry edge. It forces the second case by raising `kernel_enter` during the fuse write itself.

In both cases the bench then checks the following: the supervisor bit still reads 1, the fuse reads idle, and the supervisor bit stays at 1 for several more cycles. It also checks that translation falls back to task 0.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // Register window, in 16-bit word numbers (byte offset / 2)
    localparam logic [10:0] W_KV_BASE = 11'h200;  // 0x400
    localparam logic [10:0] W_SUPER   = 11'h208;  // 0x410
    localparam logic [10:0] W_FUSE    = 11'h209;  // 0x412
    localparam logic [10:0] W_AKEY    = 11'h20A;  // 0x414
    localparam logic [10:0] W_OKEY    = 11'h20B;  // 0x416
    localparam logic [10:0] W_MAPEN   = 11'h20C;  // 0x418

    localparam int KEY_W   = 8;
    localparam int UNIT_W  = 3;
    localparam int TSEL_W  = 5;

    // Supervisor countdown states
    typedef enum logic [1:0] {
        FZ_SUPER = 2'd0,
        FZ_ARMED = 2'd1,
        FZ_USER  = 2'd2
    } fuse_state_e;

endpackage

// File: rtl/pmu_fuse.sv
module pmu_fuse
    import pmu_pkg::*;
#(
    parameter int FUSE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel_enter,
    input  logic              fuse_wr,
    input  logic [FUSE_W-1:0] fuse_wdata,
    output logic              super_o,
    output logic [FUSE_W-1:0] count_o
);

    localparam logic [FUSE_W-1:0] IDLE = '1;

    fuse_state_e       state_q, state_d;
    logic [FUSE_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FZ_SUPER;
            cnt_q   <= IDLE;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: LOAD, RELOAD, EXPIRE, TRAP
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cnt_q != IDLE) begin
            cnt_d = cnt_q - 1'b1;
        end
        unique case (state_q)
            FZ_SUPER: begin
                if (fuse_wr) begin
                    state_d = FZ_ARMED;                       // LOAD
                end
            end
            FZ_ARMED: begin
                if (!fuse_wr && (cnt_q == '0 || cnt_q == IDLE)) begin
                    state_d = FZ_USER;                        // EXPIRE
                end
            end
            FZ_USER: begin
                state_d = FZ_USER;
            end
            default: state_d = FZ_SUPER;
        endcase
        if (fuse_wr) begin
            cnt_d = fuse_wdata;                               // LOAD / RELOAD
        end
        if (kernel_enter) begin
            state_d = FZ_SUPER;                               // TRAP
            cnt_d   = IDLE;
        end
    end

    // Outputs
    always_comb begin
        super_o = (state_q != FZ_USER);
        count_o = cnt_q;
    end

    assert_trap_sets_super_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kernel_enter |=> (super_o && count_o == IDLE));

    assert_clear_only_on_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(super_o) |-> ($past(state_q) == FZ_ARMED &&
                            ($past(cnt_q) == '0 || $past(cnt_q) == IDLE)));

    assert_countdown_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_enter && !fuse_wr && cnt_q != IDLE) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
    import pmu_pkg::*;
#(
    parameter int UNIT_ID = 0,
    parameter int TASK_W  = 2,
    parameter int IDX_W   = 9,
    parameter int FUSE_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_we,
    input  logic [11:0]       io_addr,
    input  logic [15:0]       io_wdata,
    input  logic              super_i,
    input  logic [FUSE_W-1:0] fuse_cnt_i,
    output logic              fuse_wr_o,
    output logic [FUSE_W-1:0] fuse_wdata_o,
    output logic              map_sel_o,
    output logic              map_grant_o,
    output logic [TASK_W-1:0] acc_task_o,
    output logic [IDX_W-1:0]  acc_idx_o,
    output logic [TASK_W-1:0] act_task_o,
    output logic              xlate_on_o,
    output logic [15:0]       reg_rdata_o
);

    localparam int          NUM_TASKS = 1 << TASK_W;
    localparam int          MAP_DEPTH = 1 << IDX_W;
    localparam logic [10:0] W_KV_ME   = W_KV_BASE + 11'(UNIT_ID);

    logic [10:0]       word;
    logic              aligned, wr_en;
    logic [UNIT_W-1:0] kv_q;
    logic [KEY_W-1:0]  akey_q, okey_q;
    logic              en_q;
    logic              akey_fit, okey_fit, okey_mine;

    assign word    = io_addr[11:1];
    assign aligned = (io_addr[0] == 1'b0);
    assign wr_en   = io_sel && io_we && aligned;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kv_q   <= '0;
            akey_q <= '0;
            okey_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            if (word == W_KV_ME) kv_q   <= io_wdata[UNIT_W-1:0];
            if (word == W_AKEY)  akey_q <= io_wdata[KEY_W-1:0];
            if (word == W_OKEY)  okey_q <= io_wdata[KEY_W-1:0];
            if (word == W_MAPEN) en_q   <= io_wdata[0];
        end
    end

    assign akey_fit  = ({1'b0, akey_q[TSEL_W-1:0]} < 6'(NUM_TASKS));
    assign okey_fit  = ({1'b0, okey_q[TSEL_W-1:0]} < 6'(NUM_TASKS));
    assign okey_mine = (okey_q[KEY_W-1:TSEL_W] == kv_q) && okey_fit;

    always_comb begin
        map_sel_o    = io_sel && aligned && (word[10:9] == 2'b00) &&
                       ({1'b0, word[8:0]} < 10'(MAP_DEPTH));
        map_grant_o  = map_sel_o && super_i && akey_fit &&
                       (akey_q[KEY_W-1:TSEL_W] == kv_q);
        acc_task_o   = akey_q[TASK_W-1:0];
        acc_idx_o    = word[IDX_W-1:0];
        fuse_wr_o    = wr_en && (word == W_FUSE);
        fuse_wdata_o = io_wdata[FUSE_W-1:0];
        if (super_i) begin
            act_task_o = '0;
            xlate_on_o = en_q;
        end else begin
            act_task_o = okey_q[TASK_W-1:0];
            xlate_on_o = en_q && okey_mine;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (io_sel && aligned) begin
            if (word == W_KV_ME)        reg_rdata_o = 16'(kv_q);
            else if (word == W_SUPER)   reg_rdata_o = 16'(super_i);
            else if (word == W_FUSE)    reg_rdata_o = 16'(fuse_cnt_i);
            else if (word == W_AKEY)    reg_rdata_o = 16'(akey_q);
            else if (word == W_OKEY)    reg_rdata_o = 16'(okey_q);
            else if (word == W_MAPEN)   reg_rdata_o = 16'(en_q);
        end
    end

    assert_kv_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && word == W_KV_ME) |=> $stable(kv_q));

endmodule

// File: rtl/pmu_maptab.sv
module pmu_maptab #(
    parameter int TASK_W   = 2,
    parameter int IDX_W    = 9,
    parameter int PPN_W    = 10,
    parameter int PAGE_LSB = 18,
    parameter int VA_W     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_grant,
    input  logic [TASK_W-1:0] bus_task,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              xlate_on,
    input  logic [TASK_W-1:0] act_task,
    input  logic              va_valid,
    input  logic              va_write,
    input  logic              va_io,
    input  logic [VA_W-1:0]   va,
    output logic [VA_W-1:0]   pa,
    output logic              wp_fault
);

    localparam int NUM_ENT = 1 << (TASK_W + IDX_W);
    localparam int ENT_W   = PPN_W + 1;

    logic [ENT_W-1:0] mem [NUM_ENT];
    logic [ENT_W-1:0] bus_ent, xl_ent;
    logic [IDX_W-1:0] va_idx;
    logic             mapped, fault_q;

    always_ff @(posedge clk) begin
        if (bus_wr && bus_grant) begin
            mem[{bus_task, bus_idx}] <= {bus_wdata[15], bus_wdata[PPN_W-1:0]};
        end
    end

    assign bus_ent   = mem[{bus_task, bus_idx}];
    assign bus_rdata = bus_grant ? {bus_ent[PPN_W], 5'b0, 10'(bus_ent[PPN_W-1:0])} : 16'h0000;

    assign va_idx = va[PAGE_LSB +: IDX_W];
    assign xl_ent = mem[{act_task, va_idx}];
    assign mapped = xlate_on && !va_io;

    always_comb begin
        pa = va;
        if (mapped) begin
            pa[PAGE_LSB +: PPN_W] = xl_ent[PPN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= va_valid && va_write && mapped && xl_ent[PPN_W];
    end
    assign wp_fault = fault_q;

    assert_fault_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wp_fault |-> $past(va_valid && va_write && !va_io));

endmodule

// File: rtl/pmu_top.sv
module pmu_top #(
    parameter int UNIT_ID  = 0,
    parameter int TASK_W   = 2,
    parameter int IDX_W    = 9,
    parameter int PPN_W    = 10,
    parameter int PAGE_LSB = 18,
    parameter int FUSE_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        kernel_enter,
    input  logic        io_sel,
    input  logic        io_we,
    input  logic [11:0] io_addr,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata,
    input  logic        va_valid,
    input  logic        va_write,
    input  logic        va_io,
    input  logic [63:0] va,
    output logic [63:0] pa,
    output logic        wp_fault
);

    logic              super_s, fuse_wr, map_sel, map_grant, xlate_on;
    logic [FUSE_W-1:0] fuse_cnt, fuse_wdata;
    logic [TASK_W-1:0] acc_task, act_task;
    logic [IDX_W-1:0]  acc_idx;
    logic [15:0]       reg_rdata, map_rdata;

    pmu_fuse #(.FUSE_W(FUSE_W)) u_fuse (
        .clk(clk), .rst_n(rst_n), .kernel_enter(kernel_enter),
        .fuse_wr(fuse_wr), .fuse_wdata(fuse_wdata),
        .super_o(super_s), .count_o(fuse_cnt)
    );

    pmu_regs #(.UNIT_ID(UNIT_ID), .TASK_W(TASK_W), .IDX_W(IDX_W), .FUSE_W(FUSE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .super_i(super_s),
        .fuse_cnt_i(fuse_cnt), .fuse_wr_o(fuse_wr), .fuse_wdata_o(fuse_wdata),
        .map_sel_o(map_sel), .map_grant_o(map_grant), .acc_task_o(acc_task),
        .acc_idx_o(acc_idx), .act_task_o(act_task), .xlate_on_o(xlate_on),
        .reg_rdata_o(reg_rdata)
    );

    pmu_maptab #(.TASK_W(TASK_W), .IDX_W(IDX_W), .PPN_W(PPN_W),
                 .PAGE_LSB(PAGE_LSB), .VA_W(64)) u_map (
        .clk(clk), .rst_n(rst_n), .bus_wr(io_we), .bus_grant(map_grant),
        .bus_task(acc_task), .bus_idx(acc_idx), .bus_wdata(io_wdata),
        .bus_rdata(map_rdata), .xlate_on(xlate_on), .act_task(act_task),
        .va_valid(va_valid), .va_write(va_write), .va_io(va_io), .va(va),
        .pa(pa), .wp_fault(wp_fault)
    );

    assign io_rdata = map_sel ? map_rdata : reg_rdata;

    assert_io_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        va_io |-> (pa == va));

    assert_refused_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_sel && !io_we && !super_s) |-> (io_rdata == 16'h0000));

endmodule

// File: tb/sim_pmu_top.sv
`timescale 1ns/1ps
module sim_pmu_top;

    typedef struct packed {
        logic [63:0] va;
        logic        io;
        logic        pass;
        logic [9:0]  page;
    } vec_t;

    // Translation vectors for task 0 with translation on
    localparam vec_t VECS [5] = '{
        '{va: {36'hABCDE_F012, 1'b1, 9'd3,   18'h2_1234}, io: 1'b0, pass: 1'b0, page: 10'h3FF},
        '{va: {36'h0_0000_0000, 1'b0, 9'd0,  18'h3_FFFF}, io: 1'b0, pass: 1'b0, page: 10'h155},
        '{va: {36'hFFFFF_FFFF, 1'b1, 9'd511, 18'h0_0000}, io: 1'b0, pass: 1'b0, page: 10'h001},
        '{va: {36'h12345_6789, 1'b0, 9'd3,   18'h0_0ABC}, io: 1'b1, pass: 1'b1, page: 10'h000},
        '{va: {36'h0_0000_0001, 1'b1, 9'd511, 18'h1_5555}, io: 1'b1, pass: 1'b1, page: 10'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_enter = 1'b0;
    logic        io_sel = 1'b0, io_we = 1'b0;
    logic [11:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        va_valid = 1'b0, va_write = 1'b0, va_io = 1'b0;
    logic [63:0] va = '0;
    logic [63:0] pa;
    logic        wp_fault;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmu_top u0 (
        .clk(clk), .rst_n(rst_n), .kernel_enter(kernel_enter),
        .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .va_valid(va_valid), .va_write(va_write),
        .va_io(va_io), .va(va), .pa(pa), .wp_fault(wp_fault)
    );

    localparam logic [11:0] A_KV0 = 12'h400, A_SUP = 12'h410, A_FUSE = 12'h412,
                            A_AKEY = 12'h414, A_OKEY = 12'h416, A_EN = 12'h418;

    function automatic logic [63:0] xl(input logic [63:0] a, input logic [9:0] pg);
        logic [63:0] r;
        r = a;
        r[27:18] = pg;
        return r;
    endfunction

    function automatic logic [63:0] mk_va(input logic [8:0] idx);
        return {36'h0_0000_0000, 1'b0, idx, 18'h0_1234};
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        io_sel = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk);
        @(negedge clk);
        io_sel = 1'b0; io_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [15:0] exp, input string tag);
        io_sel = 1'b1; io_we = 1'b0; io_addr = a;
        #1;
        check(64'(io_rdata), 64'(exp), tag);
        io_sel = 1'b0;
    endtask

    task automatic tr_chk(input logic [63:0] a, input logic io, input logic [63:0] exp,
                          input string tag);
        va = a; va_io = io; va_valid = 1'b1; va_write = 1'b0;
        #1;
        check(pa, exp, tag);
    endtask

    function automatic logic [11:0] ent(input int idx);
        return 12'(idx * 2);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(A_SUP,  16'h0001, "R1 supervisor");
        rd_chk(A_FUSE, 16'hFFFF, "R1 fuse idle");
        rd_chk(A_AKEY, 16'h0000, "R1 access key");
        rd_chk(A_OKEY, 16'h0000, "R1 operate key");
        rd_chk(A_EN,   16'h0000, "R1 enable");
        tr_chk(mk_va(9'd3), 1'b0, mk_va(9'd3), "R1 no translation after reset");

        // R11 unit identifier
        wr(A_KV0, 16'h0005);
        rd_chk(A_KV0, 16'h0005, "R11 own identifier");
        rd_chk(12'h402, 16'h0000, "R11 other slot");
        rd_chk(12'h40E, 16'h0000, "R11 last slot");

        // R4 key gating
        wr(A_AKEY, 16'h00A0);
        wr(ent(3), 16'h83FF);
        wr(A_AKEY, 16'h0000);
        wr(ent(3), 16'h0001);
        rd_chk(ent(3), 16'h0000, "R4 mismatched key read");
        wr(A_AKEY, 16'h00A0);
        rd_chk(ent(3), 16'h83FF, "R4 mismatched write ignored");

        // R5 entry format
        wr(ent(5), 16'hFFFF);
        rd_chk(ent(5), 16'h83FF, "R5 entry fields");
        wr(ent(0), 16'h0155);
        wr(ent(511), 16'h0001);
        wr(A_AKEY, 16'h00A1);
        wr(ent(3), 16'h00AA);
        wr(ent(7), 16'h8200);
        wr(A_AKEY, 16'h00A5);
        wr(ent(3), 16'h0123);
        rd_chk(ent(3), 16'h0000, "R4 task out of range read");
        wr(A_AKEY, 16'h00A1);
        rd_chk(ent(3), 16'h00AA, "R4 task out of range write ignored");

        // R2/R3 vector walk, task 0 active under supervisor
        wr(A_EN, 16'h0001);
        wr(A_OKEY, 16'h00A1);
        rd_chk(A_EN, 16'h0001, "R3 enable set");
        for (int i = 0; i < 5; i++) begin
            tr_chk(VECS[i].va, VECS[i].io,
                   VECS[i].pass ? VECS[i].va : xl(VECS[i].va, VECS[i].page),
                   VECS[i].pass ? "R3 io passthrough" : "R2 translation");
        end

        // R10 write protect fault
        va = mk_va(9'd3); va_io = 1'b0; va_valid = 1'b1; va_write = 1'b1;
        step(1);
        check(64'(wp_fault), 64'd1, "R10 fault raised");
        check(pa, xl(mk_va(9'd3), 10'h3FF), "R10 still translated");
        va_valid = 1'b0; va_write = 1'b0;
        step(1);
        check(64'(wp_fault), 64'd0, "R10 fault one cycle");
        va = mk_va(9'd0); va_valid = 1'b1; va_write = 1'b1;
        step(1);
        check(64'(wp_fault), 64'd0, "R10 unprotected write");
        va_valid = 1'b0; va_write = 1'b0;

        // R8 read-only supervisor bit
        wr(A_SUP, 16'h0000);
        rd_chk(A_SUP, 16'h0001, "R8 write 0 ignored");

        // R7 countdown
        wr(A_FUSE, 16'h0003);
        rd_chk(A_FUSE, 16'h0003, "R7 fuse loaded");
        step(1);
        rd_chk(A_FUSE, 16'h0002, "R7 fuse decrement");
        step(2);
        rd_chk(A_FUSE, 16'h0000, "R7 fuse at zero");
        rd_chk(A_SUP, 16'h0001, "R7 still supervisor");
        step(1);
        rd_chk(A_SUP, 16'h0000, "R7 supervisor cleared");
        rd_chk(A_FUSE, 16'hFFFF, "R7 fuse at -1");

        // R6 operate key in user mode
        tr_chk(mk_va(9'd3), 1'b0, xl(mk_va(9'd3), 10'h0AA), "R6 operate key task");
        rd_chk(ent(3), 16'h0000, "R4 refused in user mode");
        va = mk_va(9'd7); va_valid = 1'b1; va_write = 1'b1;
        step(1);
        check(64'(wp_fault), 64'd1, "R10 fault in user task");
        va_valid = 1'b0; va_write = 1'b0;
        wr(A_SUP, 16'h0001);
        rd_chk(A_SUP, 16'h0000, "R8 write 1 ignored");
        wr(A_OKEY, 16'h0041);
        tr_chk(mk_va(9'd3), 1'b0, mk_va(9'd3), "R6 other unit selected");
        wr(A_OKEY, 16'h00A1);

        // R9 kernel entry
        kernel_enter = 1'b1;
        step(1);
        kernel_enter = 1'b0;
        rd_chk(A_SUP, 16'h0001, "R9 kernel entry");
        tr_chk(mk_va(9'd3), 1'b0, xl(mk_va(9'd3), 10'h3FF), "R9 task 0 again");

        // R9 kernel entry on the expiry edge
        wr(A_FUSE, 16'h0001);
        step(1);
        kernel_enter = 1'b1;
        step(1);
        kernel_enter = 1'b0;
        rd_chk(A_SUP, 16'h0001, "R9 entry beats expiry");
        rd_chk(A_FUSE, 16'hFFFF, "R9 countdown cancelled");
        step(3);
        rd_chk(A_SUP, 16'h0001, "R9 stays supervisor");

        // R9 kernel entry with a fuse write
        kernel_enter = 1'b1;
        wr(A_FUSE, 16'h0002);
        kernel_enter = 1'b0;
        rd_chk(A_FUSE, 16'hFFFF, "R9 entry beats fuse write");
        step(4);
        rd_chk(A_SUP, 16'h0001, "R9 no countdown started");

        // R12 restart
        wr(A_FUSE, 16'h0002);
        step(1);
        wr(A_FUSE, 16'h0002);
        step(2);
        rd_chk(A_SUP, 16'h0001, "R12 restarted countdown");
        rd_chk(A_FUSE, 16'h0000, "R12 count at zero");
        step(1);
        rd_chk(A_SUP, 16'h0000, "R12 expiry after restart");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule